// File: doc/BRIEF.md
# Dual-Channel ATA PIO Cycle Timer

This block times programmed-I/O register and data cycles on two independent ATA channels, each of which serves a master and a slave drive. A cycle has three phases in a fixed order: address setup with no strobe, then the read or write strobe held for the active phase, then recovery with the strobe released. Each phase length in clocks comes from small per-drive timing bytes held in a configuration register file.

Software loads the register file through a byte-wide port. Register writes can replace a whole byte. On the setup registers they can also merge only the two-bit setup code and keep the lower six bits. A host issues a cycle with a single-clock request that carries the channel, the drive and the direction. The block acknowledges it in the same clock when that channel is idle, latches the timing for the selected drive, and returns a busy flag and a one-clock done pulse per channel.

Top module: `ata_pio_timer`

## Requirements
- R1: After reset, read-back gives 0x40 at register indices 0, 2 and 4 (setup registers) and 0x3f at indices 1, 3, 5 and 6 (active/recovery registers). Read data is combinational on `cfg_addr[2:0]`.
- R2: A write with `cfg_addr[3]`=1 to index 0, 2 or 4 replaces only bits 7:6 with `cfg_wdata[7:6]` and keeps bits 5:0. A write with `cfg_addr[3]`=0 replaces the whole byte.
- R3: The setup code is bits 7:6 of the selected setup register. Code 01 gives 2 clocks, 10 gives 3, 00 gives 4 and 11 gives 5 clocks of setup before the strobe.
- R4: The active length is bits 7:4 of the drive's active/recovery register. A value n of 1 to 15 gives n clocks and 0 gives 16 clocks.
- R5: The recovery length is bits 3:0 of the same register. A value v of 1 to 15 gives v+1 clocks and 0 gives 16 clocks. The strobe is low for the whole recovery phase.
- R6: Channel 0 uses index 0 (drive 0) or index 2 (drive 1) for setup. Channel 1 uses index 4 for both drives. The active/recovery bytes are at index 1 and 3 for channel 0 and at index 5 and 6 for channel 1.
- R7: `rd_stb` (when `req_wr`=0) or `wr_stb` (when `req_wr`=1) is high for exactly the active phase. The other strobe stays low and neither is high outside a cycle.
- R8: `busy` is high for exactly setup+active+recovery clocks after the accepting edge. `done` is high for one clock, which is the last recovery clock.
- R9: `ack` is high only when `req` is high and the requested channel's `busy` is low. A request to a busy channel is dropped and starts no cycle.
- R10: Register writes made during a cycle do not change that cycle and apply from the next accepted cycle.
- R11: Both channels can run cycles at the same time without affecting each other's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Bits 2:0 register index; bit 3 selects setup-field merge write |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data for index `cfg_addr[2:0]` |
| req | input | 1 | Cycle request, one clock |
| req_ch | input | 1 | Requested channel |
| req_drv | input | 1 | Requested drive (0 master, 1 slave) |
| req_wr | input | 1 | 1 write cycle, 0 read cycle |
| ack | output | 1 | Request accepted this clock |
| rd_stb | output | 2 | Read strobe per channel |
| wr_stb | output | 2 | Write strobe per channel |
| busy | output | 2 | Cycle in progress per channel |
| done | output | 2 | Last clock of a cycle per channel |

## Verification
The block has no parameters, so the bench instantiates its single fixed shape of two channels, two drives each and seven timing registers. That shape already reaches every encoding edge. The bench covers all four setup codes, the zero-means-sixteen cases of both the active and recovery fields, the shortest two-clock recovery, and the shared setup register on channel 1. It also covers overlapping cycles on both channels and a rejected request to a busy channel.

// File: rtl/ata_pio_timer.sv
module ata_pio_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [3:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       req,
  input  logic       req_ch,
  input  logic       req_drv,
  input  logic       req_wr,
  output logic       ack,
  output logic [1:0] rd_stb,
  output logic [1:0] wr_stb,
  output logic [1:0] busy,
  output logic [1:0] done
);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACT, PH_REC} phase_t;

  logic [7:0] regs [0:7];
  logic [2:0] idx;
  logic       idx_setup;

  assign idx       = cfg_addr[2:0];
  assign idx_setup = (idx == 3'd0) || (idx == 3'd2) || (idx == 3'd4);
  assign cfg_rdata = regs[idx];
  assign ack       = req && !busy[req_ch];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs[0] <= 8'h40; regs[1] <= 8'h3f;
      regs[2] <= 8'h40; regs[3] <= 8'h3f;
      regs[4] <= 8'h40; regs[5] <= 8'h3f;
      regs[6] <= 8'h3f; regs[7] <= 8'h00;
    end else if (cfg_we && idx != 3'd7) begin
      if (cfg_addr[3]) begin
        if (idx_setup) regs[idx][7:6] <= cfg_wdata[7:6];
      end else begin
        regs[idx] <= cfg_wdata;
      end
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    phase_t     phase;
    logic [3:0] cnt, act_q, rec_q;
    logic       wr_q;
    logic [7:0] su_byte, tm_byte;
    logic [3:0] su_m1, act_m1, rec_m1;
    logic       take;

    if (c == 0) begin : g_pri
      assign su_byte = req_drv ? regs[2] : regs[0];
      assign tm_byte = req_drv ? regs[3] : regs[1];
    end else begin : g_sec
      assign su_byte = regs[4];
      assign tm_byte = req_drv ? regs[6] : regs[5];
    end

    always_comb begin
      case (su_byte[7:6])
        2'b01:   su_m1 = 4'd1;
        2'b10:   su_m1 = 4'd2;
        2'b00:   su_m1 = 4'd3;
        default: su_m1 = 4'd4;
      endcase
    end

    assign act_m1 = tm_byte[7:4] - 4'd1;
    assign rec_m1 = (tm_byte[3:0] == 4'd0) ? 4'd15 : tm_byte[3:0];
    assign take   = ack && (req_ch == 1'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        phase <= PH_IDLE;
        cnt   <= '0;
        act_q <= '0;
        rec_q <= '0;
        wr_q  <= 1'b0;
      end else begin
        case (phase)
          PH_IDLE: if (take) begin
            phase <= PH_SETUP;
            cnt   <= su_m1;
            act_q <= act_m1;
            rec_q <= rec_m1;
            wr_q  <= req_wr;
          end
          PH_SETUP: if (cnt == 4'd0) begin
            phase <= PH_ACT;
            cnt   <= act_q;
          end else cnt <= cnt - 4'd1;
          PH_ACT: if (cnt == 4'd0) begin
            phase <= PH_REC;
            cnt   <= rec_q;
          end else cnt <= cnt - 4'd1;
          default: if (cnt == 4'd0) phase <= PH_IDLE;
                   else cnt <= cnt - 4'd1;
        endcase
      end
    end

    assign busy[c]   = (phase != PH_IDLE);
    assign done[c]   = (phase == PH_REC) && (cnt == 4'd0);
    assign rd_stb[c] = (phase == PH_ACT) && !wr_q;
    assign wr_stb[c] = (phase == PH_ACT) && wr_q;
  end

endmodule

module ata_pio_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req,
  input logic       req_ch,
  input logic       ack,
  input logic [1:0] rd_stb,
  input logic [1:0] wr_stb,
  input logic [1:0] busy,
  input logic [1:0] done
);
  for (genvar c = 0; c < 2; c++) begin : g_a
    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_stb[c] && wr_stb[c]));
    assert_strobe_in_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb[c] || wr_stb[c]) |-> busy[c]);
    assert_done_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done[c] |=> !busy[c]);
    assert_accept_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && req && req_ch == 1'(c)) |=> (busy[c] && !rd_stb[c] && !wr_stb[c]));
    assert_recovery_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_stb[c] || wr_stb[c]) |-> (busy[c] && !done[c]));
  end
endmodule

bind ata_pio_timer ata_pio_timer_chk u_chk (.*);

// File: tb/ata_pio_timer_tb.sv
`timescale 1ns/1ps
module ata_pio_timer_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [3:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic req = 0, req_ch = 0, req_drv = 0, req_wr = 0, ack;
  logic [1:0] rd_stb, wr_stb, busy, done;

  int errors = 0, checks = 0, cyc = 0;
  int acc_cyc[2], acc_n[2], rise[2], rd_n[2], wr_n[2], done_cyc[2], done_n[2], busy_n[2];
  logic prev_s[2];
  logic last_ack;

  always #4 clk = ~clk;

  ata_pio_timer u_dut (.*);

  always @(negedge clk) begin
    cyc++;
    if (req && ack) begin acc_cyc[req_ch] = cyc; acc_n[req_ch]++; end
    for (int c = 0; c < 2; c++) begin
      if ((rd_stb[c] || wr_stb[c]) && !prev_s[c]) rise[c] = cyc;
      prev_s[c] = rd_stb[c] || wr_stb[c];
      if (rd_stb[c]) rd_n[c]++;
      if (wr_stb[c]) wr_n[c]++;
      if (done[c]) begin done_cyc[c] = cyc; done_n[c]++; end
      if (busy[c]) busy_n[c]++;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr(int c);
    acc_n[c] = 0; rd_n[c] = 0; wr_n[c] = 0; done_n[c] = 0; busy_n[c] = 0;
    acc_cyc[c] = -100; rise[c] = -100; done_cyc[c] = -100;
  endtask

  task automatic wreg(logic [3:0] a, logic [7:0] d);
    @(posedge clk); #1;
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic rreg(string tag, logic [2:0] a, logic [7:0] exp);
    @(posedge clk); #1;
    cfg_addr = {1'b0, a}; #1;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic issue(logic ch, logic drv, logic wr);
    @(posedge clk); #1;
    req = 1; req_ch = ch; req_drv = drv; req_wr = wr;
    @(negedge clk); last_ack = ack;
    @(posedge clk); #1;
    req = 0;
  endtask

  task automatic verify(string tag, int c, logic wr, int s, int a, int r);
    chk({tag, " accepted"}, acc_n[c], 1);
    chk({tag, " setup clocks"}, rise[c] - acc_cyc[c] - 1, s);
    chk({tag, " active clocks"}, wr ? wr_n[c] : rd_n[c], a);
    chk({tag, " other strobe R7"}, wr ? rd_n[c] : wr_n[c], 0);
    chk({tag, " done position R8"}, done_cyc[c] - acc_cyc[c], s + a + r);
    chk({tag, " done count R8"}, done_n[c], 1);
    chk({tag, " busy clocks R8"}, busy_n[c], s + a + r);
  endtask

  task automatic run_one(string tag, logic ch, logic drv, logic wr, int s, int a, int r);
    clr(ch);
    issue(ch, drv, wr);
    repeat (s + a + r + 3) @(posedge clk);
    verify(tag, ch, wr, s, a, r);
  endtask

  task automatic t_reset;
    chk("R1 busy after reset", busy, 0);
    chk("R1 strobes after reset", {rd_stb, wr_stb}, 0);
    rreg("R1 idx0", 0, 8'h40); rreg("R1 idx1", 1, 8'h3f);
    rreg("R1 idx2", 2, 8'h40); rreg("R1 idx3", 3, 8'h3f);
    rreg("R1 idx4", 4, 8'h40); rreg("R1 idx5", 5, 8'h3f);
    rreg("R1 idx6", 6, 8'h3f);
  endtask

  task automatic t_default_cycle;
    run_one("R3/R4/R5 reset timing read", 0, 0, 0, 2, 3, 16);
  endtask

  task automatic t_field_write;
    wreg(4'd2, 8'h15);
    wreg(4'd10, 8'hFF);
    rreg("R2 merge keeps low bits", 2, 8'hD5);
    wreg(4'd2, 8'h2A);
    rreg("R2 full byte write", 2, 8'h2A);
  endtask

  task automatic t_setup_codes;
    wreg(4'd3, 8'h12);
    wreg(4'd2, 8'h80); run_one("R3 code10", 0, 1, 1, 3, 1, 3);
    wreg(4'd2, 8'h00); run_one("R3 code00", 0, 1, 1, 4, 1, 3);
    wreg(4'd2, 8'hC0); run_one("R3 code11", 0, 1, 0, 5, 1, 3);
    wreg(4'd2, 8'h40); run_one("R3 code01", 0, 1, 1, 2, 1, 3);
  endtask

  task automatic t_fields;
    wreg(4'd1, 8'h01); run_one("R4 active zero=16", 0, 0, 0, 2, 16, 2);
    wreg(4'd1, 8'h40); run_one("R5 recovery zero=16", 0, 0, 1, 2, 4, 16);
    wreg(4'd1, 8'hF1); run_one("R4 active 15 R5 rec 2", 0, 0, 0, 2, 15, 2);
  endtask

  task automatic t_shared;
    wreg(4'd12, 8'hC0);
    wreg(4'd5, 8'h21); wreg(4'd6, 8'h31);
    wreg(4'd0, 8'h80); wreg(4'd2, 8'h00); wreg(4'd1, 8'h11); wreg(4'd3, 8'h11);
    run_one("R6 sec drv0 shared setup", 1, 0, 0, 5, 2, 2);
    run_one("R6 sec drv1 shared setup", 1, 1, 1, 5, 3, 2);
    run_one("R6 pri drv0 own setup", 0, 0, 0, 3, 1, 2);
    run_one("R6 pri drv1 own setup", 0, 1, 0, 4, 1, 2);
  endtask

  task automatic t_busy_reject;
    wreg(4'd0, 8'h40); wreg(4'd1, 8'h22);
    clr(0);
    issue(0, 0, 0);
    chk("R9 idle channel acks", last_ack, 1);
    repeat (2) @(posedge clk);
    issue(0, 1, 1);
    chk("R9 busy channel no ack", last_ack, 0);
    repeat (12) @(posedge clk);
    verify("R9 dropped request", 0, 0, 2, 2, 3);
  endtask

  task automatic t_midcycle;
    wreg(4'd1, 8'h22);
    clr(0);
    issue(0, 0, 1);
    wreg(4'd1, 8'h51);
    repeat (10) @(posedge clk);
    verify("R10 write during cycle", 0, 1, 2, 2, 3);
    run_one("R10 next cycle new timing", 0, 0, 1, 2, 5, 2);
  endtask

  task automatic t_concurrent;
    wreg(4'd1, 8'h33); wreg(4'd6, 8'h24);
    clr(0); clr(1);
    issue(0, 0, 0);
    issue(1, 1, 1);
    chk("R11 second channel acked", last_ack, 1);
    repeat (20) @(posedge clk);
    verify("R11 ch0 overlapped", 0, 0, 2, 3, 4);
    verify("R11 ch1 overlapped", 1, 1, 5, 2, 5);
  endtask

  initial begin
    clr(0); clr(1); prev_s[0] = 0; prev_s[1] = 0;
    repeat (3) @(posedge clk); #1 rst_n = 1;
    t_reset;
    t_default_cycle;
    t_field_write;
    t_setup_codes;
    t_fields;
    t_shared;
    t_busy_reject;
    t_midcycle;
    t_concurrent;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule